// File: doc/BRIEF.md
# Masked Burst Address Counter

This block generates addresses for one memory port. A start address is taken from the address input bus and kept; the counter then advances by one on each access strobe. A mask register chooses which low address bits take part in counting, so a burst cycles inside an aligned block of two to the power of the mask width. Bits above the mask keep their loaded value.

When the counting field rolls over from all ones to zero, a sticky interrupt flag is raised. A retransmit strobe returns the counter to the last loaded start address, so a burst can be replayed. The counter value or the mask value can be read back on the address output, chosen by a select input. An active-low asynchronous reset puts everything in a known state.

Top module: `mbc_counter`

## Requirements
- R1: While reset is low, the counter and the stored start address are 0, the mask is all ones and `wrap_irq` is 0.
- R2: `load` copies `addr_in` into the counter and the start address at the next clock edge and clears `wrap_irq`.
- R3: `inc` adds one to the counter bits whose mask bit is 1; bits whose mask bit is 0 are unchanged.
- R4: An `inc` while all masked counter bits are 1 sets those bits to 0 and sets `wrap_irq` at the same edge.
- R5: `wrap_irq` stays 1 until `load` or `irq_clr`; when a wrap and `irq_clr` fall in the same cycle, the flag ends up 1.
- R6: `rtx` sets the counter to the stored start address at the next edge.
- R7: Within a cycle `load` wins over `rtx`, and `rtx` wins over `inc`.
- R8: `mask_ld` writes the mask from `addr_in` at the next edge, keeping bit i only if bits 0 to i of `addr_in` are all 1; an `inc` in that same cycle counts with the old mask.
- R9: `addr_out` shows the mask when `rd_mask` is 1 and the counter when it is 0, with no added cycle.
- R10: With a mask of zero, `inc` leaves the counter unchanged and sets `wrap_irq`.
- R11: With no strobe asserted, the counter, mask and flag keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_in | input | AW | Start address or mask value |
| load | input | 1 | Load counter and start address |
| rtx | input | 1 | Return counter to start address |
| inc | input | 1 | Advance counter |
| mask_ld | input | 1 | Write mask register |
| irq_clr | input | 1 | Clear wrap interrupt |
| rd_mask | input | 1 | Readback select: 1 mask, 0 counter |
| addr_out | output | AW | Counter or mask readback |
| wrap_irq | output | 1 | Sticky wrap interrupt flag |

## Verification
The bench runs a small 4-bit instance over every mask and every start address, counting past the wrap each time. Two functions meet in one cycle in several places: a wrap that coincides with `irq_clr`, a mask write that coincides with an increment, and `load`, `rtx` and `inc` asserted together. Each of these is driven in a single cycle, and the next counter, mask and flag values are judged against an arithmetic model built from the priority and set-over-clear rules.

// File: rtl/mbc_counter.sv
module mbc_counter #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_in,
  input  logic          load,
  input  logic          rtx,
  input  logic          inc,
  input  logic          mask_ld,
  input  logic          irq_clr,
  input  logic          rd_mask,
  output logic [AW-1:0] addr_out,
  output logic          wrap_irq
);

  logic [AW-1:0] cnt, start, mask;
  logic [AW-1:0] mask_new, cnt_step;
  logic          at_top;

  always_comb begin
    mask_new[0] = addr_in[0];
    for (int i = 1; i < AW; i++)
      mask_new[i] = mask_new[i-1] & addr_in[i];
  end

  assign at_top   = (cnt & mask) == mask;
  assign cnt_step = (cnt & ~mask) | ((cnt + 1'b1) & mask);
  assign addr_out = rd_mask ? mask : cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      start <= '0;
    end else if (load) begin
      cnt   <= addr_in;
      start <= addr_in;
    end else if (rtx) begin
      cnt   <= start;
    end else if (inc) begin
      cnt   <= cnt_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= '1;
    else if (mask_ld) mask <= mask_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           wrap_irq <= 1'b0;
    else if (load)                        wrap_irq <= 1'b0;
    else if (!rtx && inc && at_top)       wrap_irq <= 1'b1;
    else if (irq_clr)                     wrap_irq <= 1'b0;
  end

endmodule

// File: rtl/mbc_counter_chk.sv
module mbc_counter_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr_in,
  input logic          load,
  input logic          rtx,
  input logic          inc,
  input logic          irq_clr,
  input logic [AW-1:0] cnt,
  input logic [AW-1:0] start,
  input logic [AW-1:0] mask,
  input logic          wrap_irq
);

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(addr_in)) && !wrap_irq);

  assert_upper_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !rtx) |=> ((cnt & ~$past(mask)) == $past(cnt & ~mask)));

  assert_wrap_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && !rtx && ((cnt & mask) == mask)) |=> wrap_irq && ((cnt & $past(mask)) == '0));

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_irq && !load && !irq_clr) |=> wrap_irq);

  assert_rtx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rtx && !load) |=> cnt == $past(start));

  assert_mask_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask + 1'b1) & mask) == '0);

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !rtx && !inc) |=> $stable(cnt));

endmodule

bind mbc_counter mbc_counter_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .load(load), .rtx(rtx),
  .inc(inc), .irq_clr(irq_clr), .cnt(cnt), .start(start), .mask(mask),
  .wrap_irq(wrap_irq)
);

// File: tb/sim_mbc_counter.sv
`timescale 1ns/1ps
module sim_mbc_counter;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic load = 0, rtx = 0, inc = 0, mask_ld = 0, irq_clr = 0, rd_mask = 0;
  logic [AW-1:0] addr_out;
  logic wrap_irq;

  always #2.5 clk = ~clk;

  mbc_counter #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .load(load), .rtx(rtx),
    .inc(inc), .mask_ld(mask_ld), .irq_clr(irq_clr), .rd_mask(rd_mask),
    .addr_out(addr_out), .wrap_irq(wrap_irq)
  );

  int runs = 0, fails = 0;
  logic [AW-1:0] m_cnt, m_start, m_mask;
  logic m_irq;

  function automatic logic [AW-1:0] shape(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    logic run;
    run = 1'b1;
    for (int i = 0; i < AW; i++) begin
      run = run & v[i];
      r[i] = run;
    end
    return r;
  endfunction

  task automatic check(input string tag);
    logic [AW-1:0] exp_a;
    exp_a = rd_mask ? m_mask : m_cnt;
    runs++;
    if (addr_out !== exp_a || wrap_irq !== m_irq) begin
      fails++;
      $display("FAIL %s: addr_out=%0h irq=%0b expected addr_out=%0h irq=%0b",
               tag, addr_out, wrap_irq, exp_a, m_irq);
    end
  endtask

  task automatic cyc(input logic ld, input logic rt, input logic in, input logic ml,
                     input logic clr, input logic rb, input logic [AW-1:0] din,
                     input string tag);
    logic setw;
    load = ld; rtx = rt; inc = in; mask_ld = ml; irq_clr = clr; rd_mask = rb; addr_in = din;
    @(posedge clk);
    setw = 1'b0;
    if (ld) begin
      m_cnt = din; m_start = din;
    end else if (rt) begin
      m_cnt = m_start;
    end else if (in) begin
      if ((m_cnt & m_mask) == m_mask) setw = 1'b1;
      m_cnt = (m_cnt & ~m_mask) | ((m_cnt + 1'b1) & m_mask);
    end
    if (ld) m_irq = 1'b0;
    else if (setw) m_irq = 1'b1;
    else if (clr) m_irq = 1'b0;
    if (ml) m_mask = shape(din);
    #1;
    load = 0; rtx = 0; inc = 0; mask_ld = 0; irq_clr = 0;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    m_cnt = '0; m_start = '0; m_mask = '1; m_irq = 1'b0;
    repeat (3) @(negedge clk);
    rd_mask = 0; #0.1; check("R1 counter");
    rd_mask = 1; #0.1; check("R1 mask");
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 R8 sweep of every raw mask value and every start
    for (int mv = 0; mv < (1 << AW); mv++) begin
      cyc(0, 0, 0, 1, 0, 1, AW'(mv), "R8 mask write");
      for (int sv = 0; sv < (1 << AW); sv++) begin
        cyc(1, 0, 0, 0, 0, 0, AW'(sv), "R2 load");
        for (int k = 0; k < (1 << AW) + 2; k++)
          cyc(0, 0, 1, 0, 0, 0, '0, "R3 R4 increment");
        cyc(0, 1, 0, 0, 0, 0, '0, "R6 retransmit");
        cyc(0, 0, 0, 0, 1, 0, '0, "R5 clear");
      end
    end

    // R10 zero mask
    cyc(0, 0, 0, 1, 0, 1, 4'b1110, "R10 mask zero");
    cyc(1, 0, 0, 0, 0, 0, 4'h9, "R2 load");
    cyc(0, 0, 1, 0, 0, 0, '0, "R10 inc with zero mask");
    cyc(0, 0, 1, 0, 1, 0, '0, "R10 inc again");

    // R5 wrap and clear together; sticky
    cyc(0, 0, 0, 1, 0, 1, 4'b0011, "R8 mask 3");
    cyc(1, 0, 0, 0, 0, 0, 4'hB, "R2 load");
    cyc(0, 0, 1, 0, 1, 0, '0, "R5 wrap with clear");
    cyc(0, 0, 0, 0, 0, 0, '0, "R11 idle");
    cyc(0, 0, 0, 0, 0, 1, '0, "R11 idle mask");
    cyc(0, 0, 1, 0, 0, 0, '0, "R5 sticky after inc");
    cyc(0, 0, 0, 0, 1, 0, '0, "R5 clear alone");

    // R7 priority
    cyc(1, 1, 1, 0, 0, 0, 4'h6, "R7 load wins");
    cyc(0, 0, 1, 0, 0, 0, '0, "R3 inc");
    cyc(0, 1, 1, 0, 0, 0, '0, "R7 rtx wins over inc");
    cyc(0, 0, 1, 0, 0, 0, '0, "R3 inc");
    cyc(1, 0, 1, 0, 0, 0, 4'h3, "R7 load over inc");

    // R8 mask write with increment in the same cycle
    cyc(0, 0, 1, 1, 0, 0, 4'b0001, "R8 inc uses old mask");
    cyc(0, 0, 0, 0, 0, 1, '0, "R9 mask readback");
    cyc(0, 0, 1, 0, 0, 0, '0, "R8 new mask counts");
    cyc(0, 0, 0, 1, 0, 1, 4'b1011, "R8 non-contiguous write");
    cyc(0, 0, 0, 0, 0, 0, '0, "R9 counter readback");

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule